// File: doc/BRIEF.md
# Deduplicating Cache Data Store

This block is the data side of a small direct-mapped cache. It never keeps two copies of the same data word. Each cache line has one entry in a line table. That entry holds a valid bit, a tag, an inline flag and an 8-bit payload. Wide data words sit in a shared table of 256 unique words. Each slot in that table has a reference counter, and a line entry points to its word through the payload field. A word that fits in the signed 8-bit range is stored in the payload itself, marked inline, and is sign-extended when it is read. Such a word uses no shared slot.

A requester issues one operation at a time: a read with a tag compare, a write or fill of one word under a tag, or an eviction of a line. Each accepted request is answered in the following cycle with a one-cycle response. The response carries a hit flag, the read data and a reject flag. A level output, `vt_full`, reports when no shared slot is free.

The controller is a small state machine. The states are:
- `ST_IDLE`: ready for a request.
- `ST_READ`, `ST_WRITE`, `ST_EVICT`, `ST_NOP`: each lasts one cycle, gives the response and commits any table update at its closing edge.

The transitions are:
- `ST_IDLE` to the state named by the operation code, when a request is accepted.
- Each of the other states back to `ST_IDLE` unconditionally.

Top module: `ddc_store`

## Requirements
- R1: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. In the next cycle `rsp_valid` is high for exactly one cycle and `req_ready` is low. Operation codes: 0 = read, 1 = write, 2 = evict, 3 = no operation. A no operation answers with hit 0, data 0 and reject 0, and changes nothing.
- R2: A read of a valid line whose stored tag equals `req_tag` answers with `rsp_hit`=1 and the word last written to that line.
- R3: A read of an invalid line, or of a line with a different tag, answers with `rsp_hit`=0 and `rsp_data`=0.
- R4: A write of a word in the range -128..127 is stored inline and never rejected. It uses no shared slot, and it reads back sign-extended to 32 bits.
- R5: A write of a wide word that already sits in a referenced shared slot reuses that slot. It is accepted even when `vt_full` is high.
- R6: A wide write can be rejected. This happens when the word matches no slot, no slot is free, and the line does not solely own a slot. The response then has `rsp_reject`=1 and the line keeps its previous valid bit, tag and data.
- R7: `vt_full` is high exactly when all 256 shared slots have a nonzero reference count. It changes only at the edge that closes a response cycle.
- R8: Evicting or overwriting a line that references a shared slot decrements that slot's count. The slot becomes free when its count reaches zero.
- R9: Rewriting a line with the wide word it already references leaves that slot's count unchanged.
- R10: A wide write that finds no match and no free slot, to a line that is the only reference of its slot, reuses that slot for the new word and is accepted.
- R11: After an eviction, a read of that line misses.
- R12: After reset all lines are invalid, every shared slot is free, `req_ready` is 1 and `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and takes a request |
| req_op | input | 2 | Operation code (0 read, 1 write, 2 evict, 3 none) |
| req_idx | input | IDX_W (9) | Line index |
| req_tag | input | TAG_W (8) | Tag to compare or store |
| req_data | input | DATA_W (32) | Word to write |
| rsp_valid | output | 1 | Response cycle |
| rsp_hit | output | 1 | Read tag matched on a valid line |
| rsp_data | output | DATA_W (32) | Read data, zero on a miss |
| rsp_reject | output | 1 | Write refused for lack of space |
| vt_full | output | 1 | No free shared slot |

## Verification
The bench fills all 256 shared slots and then probes each edge of allocation:
- A fresh wide word is refused. A design that overwrote a slot anyway would corrupt another line, and one that committed a rejected write would lose the line's old data.
- A shared word and an inline word are still accepted while the table is full. A design that allocated blindly would reject them.
- A line that solely owns its slot can replace its own word. A design that ordered the release after the lookup would refuse it.
- Rewriting a line with the word it already holds, then evicting it, must free the slot. A design that counted the rewrite twice would leave `vt_full` stuck high.
- Evicting one of two lines that share a slot must keep the table full. A design that freed the slot on the first release would drop the flag early.

// File: rtl/ddc_pkg.sv
package ddc_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_EVICT = 2'd2,
        OP_NOP   = 2'd3
    } ddc_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_EVICT,
        ST_NOP
    } ddc_state_e;

endpackage

// File: rtl/ddc_ptr_table.sv
module ddc_ptr_table #(
    parameter int IDX_W = 9,
    parameter int TAG_W = 8,
    parameter int PTR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_inline,
    output logic [PTR_W-1:0] rd_pay,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_valid,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             wr_inline,
    input  logic [PTR_W-1:0] wr_pay
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0] vld_q;
    logic [LINES-1:0] inl_q;
    logic [TAG_W-1:0] tag_mem [LINES];
    logic [PTR_W-1:0] pay_mem [LINES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_idx] <= wr_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            inl_q[wr_idx]   <= wr_inline;
            tag_mem[wr_idx] <= wr_tag;
            pay_mem[wr_idx] <= wr_pay;
        end
    end

    assign rd_valid  = vld_q[rd_idx];
    assign rd_inline = inl_q[rd_idx];
    assign rd_tag    = tag_mem[rd_idx];
    assign rd_pay    = pay_mem[rd_idx];

endmodule

// File: rtl/ddc_value_table.sv
module ddc_value_table #(
    parameter int DATA_W = 32,
    parameter int PTR_W  = 8,
    parameter int CNT_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] look_word,
    output logic              look_hit,
    output logic [PTR_W-1:0]  look_idx,
    output logic              free_any,
    output logic [PTR_W-1:0]  free_idx,
    input  logic [PTR_W-1:0]  probe_idx,
    output logic [DATA_W-1:0] probe_word,
    output logic [CNT_W-1:0]  probe_cnt,
    input  logic              inc_en,
    input  logic [PTR_W-1:0]  inc_idx,
    input  logic              dec_en,
    input  logic [PTR_W-1:0]  dec_idx,
    input  logic              load_en,
    input  logic [PTR_W-1:0]  load_idx,
    input  logic [DATA_W-1:0] load_word
);
    localparam int DEPTH = 1 << PTR_W;

    logic [DATA_W-1:0] vals [DEPTH];
    logic [CNT_W-1:0]  cnt_w [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [CNT_W-1:0] cnt_q;
        logic             sel_load;
        logic             sel_inc;
        logic             sel_dec;
        assign sel_load = load_en && (load_idx == PTR_W'(g));
        assign sel_inc  = inc_en  && (inc_idx  == PTR_W'(g));
        assign sel_dec  = dec_en  && (dec_idx  == PTR_W'(g));
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else if (sel_load) begin
                cnt_q <= CNT_W'(1);
            end else begin
                cnt_q <= cnt_q + CNT_W'(sel_inc) - CNT_W'(sel_dec);
            end
        end
        assign cnt_w[g] = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (load_en) begin
            vals[load_idx] <= load_word;
        end
    end

    always_comb begin
        look_hit = 1'b0;
        look_idx = '0;
        free_any = 1'b0;
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (cnt_w[i] != '0 && vals[i] == look_word) begin
                look_hit = 1'b1;
                look_idx = PTR_W'(i);
            end
            if (cnt_w[i] == '0) begin
                free_any = 1'b1;
                free_idx = PTR_W'(i);
            end
        end
    end

    assign probe_word = vals[probe_idx];
    assign probe_cnt  = cnt_w[probe_idx];

endmodule

// File: rtl/ddc_store.sv
module ddc_store
    import ddc_pkg::*;
#(
    parameter int IDX_W  = 9,
    parameter int TAG_W  = 8,
    parameter int DATA_W = 32,
    parameter int PTR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [DATA_W-1:0] req_data,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_reject,
    output logic              vt_full
);
    localparam int CNT_W  = IDX_W + 1;
    localparam int HIGH_W = DATA_W - PTR_W + 1;

    ddc_state_e state_q, state_d;

    logic [IDX_W-1:0]  idx_q;
    logic [TAG_W-1:0]  tag_q;
    logic [DATA_W-1:0] data_q;

    logic             pt_valid, pt_inline;
    logic [TAG_W-1:0] pt_tag;
    logic [PTR_W-1:0] pt_pay;
    logic             pt_we, pt_wvalid, pt_winline;
    logic [PTR_W-1:0] pt_wpay;

    logic              vt_hit, vt_free;
    logic [PTR_W-1:0]  vt_hit_idx, vt_free_idx;
    logic [DATA_W-1:0] vt_word;
    logic [CNT_W-1:0]  vt_cnt;
    logic              inc_en, dec_en, load_en;
    logic [PTR_W-1:0]  inc_idx, load_idx;

    logic             old_ref, is_narrow, sole_owner;
    logic [HIGH_W-1:0] high_bits;

    ddc_ptr_table #(.IDX_W(IDX_W), .TAG_W(TAG_W), .PTR_W(PTR_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (idx_q),
        .rd_valid  (pt_valid),
        .rd_tag    (pt_tag),
        .rd_inline (pt_inline),
        .rd_pay    (pt_pay),
        .wr_en     (pt_we),
        .wr_idx    (idx_q),
        .wr_valid  (pt_wvalid),
        .wr_tag    (tag_q),
        .wr_inline (pt_winline),
        .wr_pay    (pt_wpay)
    );

    ddc_value_table #(.DATA_W(DATA_W), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_vt (
        .clk        (clk),
        .rst_n      (rst_n),
        .look_word  (data_q),
        .look_hit   (vt_hit),
        .look_idx   (vt_hit_idx),
        .free_any   (vt_free),
        .free_idx   (vt_free_idx),
        .probe_idx  (pt_pay),
        .probe_word (vt_word),
        .probe_cnt  (vt_cnt),
        .inc_en     (inc_en),
        .inc_idx    (inc_idx),
        .dec_en     (dec_en),
        .dec_idx    (pt_pay),
        .load_en    (load_en),
        .load_idx   (load_idx),
        .load_word  (data_q)
    );

    assign high_bits  = data_q[DATA_W-1:PTR_W-1];
    assign is_narrow  = (&high_bits) || !(|high_bits);
    assign old_ref    = pt_valid && !pt_inline;
    assign sole_owner = old_ref && (vt_cnt == CNT_W'(1));
    assign vt_full    = !vt_free;

    // request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            tag_q  <= '0;
            data_q <= '0;
        end else if (state_q == ST_IDLE && req_valid) begin
            idx_q  <= req_idx;
            tag_q  <= req_tag;
            data_q <= req_data;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = ST_IDLE;
        if (state_q == ST_IDLE && req_valid) begin
            unique case (ddc_op_e'(req_op))
                OP_READ:  state_d = ST_READ;
                OP_WRITE: state_d = ST_WRITE;
                OP_EVICT: state_d = ST_EVICT;
                OP_NOP:   state_d = ST_NOP;
            endcase
        end
    end

    // outputs and table updates
    always_comb begin
        req_ready  = 1'b0;
        rsp_valid  = 1'b0;
        rsp_hit    = 1'b0;
        rsp_data   = '0;
        rsp_reject = 1'b0;
        pt_we      = 1'b0;
        pt_wvalid  = 1'b1;
        pt_winline = 1'b0;
        pt_wpay    = '0;
        inc_en     = 1'b0;
        inc_idx    = vt_hit_idx;
        dec_en     = 1'b0;
        load_en    = 1'b0;
        load_idx   = vt_free_idx;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
            end
            ST_READ: begin
                rsp_valid = 1'b1;
                if (pt_valid && pt_tag == tag_q) begin
                    rsp_hit  = 1'b1;
                    rsp_data = pt_inline
                             ? {{(DATA_W-PTR_W){pt_pay[PTR_W-1]}}, pt_pay}
                             : vt_word;
                end
            end
            ST_WRITE: begin
                rsp_valid = 1'b1;
                if (is_narrow) begin
                    pt_we      = 1'b1;
                    pt_winline = 1'b1;
                    pt_wpay    = data_q[PTR_W-1:0];
                    dec_en     = old_ref;
                end else if (vt_hit && old_ref && vt_hit_idx == pt_pay) begin
                    pt_we   = 1'b1;
                    pt_wpay = pt_pay;
                end else if (vt_hit) begin
                    pt_we   = 1'b1;
                    pt_wpay = vt_hit_idx;
                    inc_en  = 1'b1;
                    dec_en  = old_ref;
                end else if (vt_free) begin
                    pt_we   = 1'b1;
                    pt_wpay = vt_free_idx;
                    load_en = 1'b1;
                    dec_en  = old_ref;
                end else if (sole_owner) begin
                    pt_we    = 1'b1;
                    pt_wpay  = pt_pay;
                    load_en  = 1'b1;
                    load_idx = pt_pay;
                end else begin
                    rsp_reject = 1'b1;
                end
            end
            ST_EVICT: begin
                rsp_valid = 1'b1;
                if (pt_valid) begin
                    pt_we     = 1'b1;
                    pt_wvalid = 1'b0;
                    pt_wpay   = pt_pay;
                    dec_en    = old_ref;
                end
            end
            ST_NOP: begin
                rsp_valid = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ddc_store_chk.sv
module ddc_store_chk
    import ddc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [1:0]        req_op,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic [DATA_W-1:0] rsp_data,
    input logic              rsp_reject,
    input logic              vt_full
);
    logic [1:0] op_q;
    logic       prev_rsp;
    logic       full_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q     <= 2'd3;
            prev_rsp <= 1'b0;
            full_q   <= 1'b0;
        end else begin
            if (req_valid && req_ready) op_q <= req_op;
            prev_rsp <= rsp_valid;
            full_q   <= vt_full;
        end
    end

    assert_resp_next_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (rsp_valid && !req_ready));

    assert_resp_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_hit_on_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (rsp_valid && op_q == OP_READ));

    assert_miss_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_data == '0));

    assert_reject_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_reject |-> (rsp_valid && vt_full && op_q == OP_WRITE));

    assert_full_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !prev_rsp |-> (vt_full == full_q));

endmodule

bind ddc_store ddc_store_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_op     (req_op),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_data   (rsp_data),
    .rsp_reject (rsp_reject),
    .vt_full    (vt_full)
);

// File: tb/ddc_store_test.sv
`timescale 1ns/1ps
module ddc_store_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'd0;
    logic [8:0]  req_idx = '0;
    logic [7:0]  req_tag = '0;
    logic [31:0] req_data = '0;
    logic        rsp_valid, rsp_hit, rsp_reject, vt_full;
    logic [31:0] rsp_data;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic        hit;
        logic [31:0] data;
        logic        rej;
        string       rq;
    } exp_t;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    ddc_store uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_idx(req_idx), .req_tag(req_tag), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
        .rsp_reject(rsp_reject), .vt_full(vt_full)
    );

    task automatic check(input logic ok, input string rq, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", rq, act, expv);
        end
    endtask

    task automatic do_op(input int op, input int idx, input int tag, input logic [31:0] d,
                         input logic e_hit, input logic [31:0] e_data, input logic e_rej,
                         input string rq);
        exp_t e;
        e.hit = e_hit; e.data = e_data; e.rej = e_rej; e.rq = rq;
        exp_q.push_back(e);
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = 2'(op);
        req_idx   = 9'(idx);
        req_tag   = 8'(tag);
        req_data  = d;
        @(posedge clk);
        #1 req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    // monitor: compare each response with the head of the queue
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R1 unexpected response", 32'(rsp_valid), 32'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(rsp_hit == e.hit && rsp_data == e.data && rsp_reject == e.rej,
                      e.rq, {rsp_hit, rsp_reject, rsp_data[29:0]}, {e.hit, e.rej, e.data[29:0]});
                check(!req_ready, "R1 ready low in response", 32'(req_ready), 32'd0);
            end
        end
    end

    localparam int RD = 0, WR = 1, EV = 2, NP = 3;

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R12 ready after reset", 32'(req_ready), 32'd1);
        check(vt_full == 1'b0, "R12 table empty after reset", 32'(vt_full), 32'd0);
        check(rsp_valid == 1'b0, "R12 no response after reset", 32'(rsp_valid), 32'd0);

        do_op(RD, 5, 3, 0, 0, 0, 0, "R12 R3 read of reset line");
        do_op(WR, 5, 3, 32'h1234_5678, 0, 0, 0, "R1 write response");
        do_op(RD, 5, 3, 0, 1, 32'h1234_5678, 0, "R2 read hit");
        do_op(RD, 5, 4, 0, 0, 0, 0, "R3 tag mismatch");
        do_op(WR, 6, 1, 32'hFFFF_FFFB, 0, 0, 0, "R4 narrow write");
        do_op(RD, 6, 1, 0, 1, 32'hFFFF_FFFB, 0, "R4 negative sign extend");
        do_op(WR, 7, 1, 32'd127, 0, 0, 0, "R4 narrow write");
        do_op(RD, 7, 1, 0, 1, 32'd127, 0, "R4 upper narrow bound");
        do_op(EV, 5, 0, 0, 0, 0, 0, "R11 evict response");
        do_op(RD, 5, 3, 0, 0, 0, 0, "R11 read after evict");

        for (int i = 0; i < 256; i++) begin
            do_op(WR, i, 1, 32'hA000_0000 + i, 0, 0, 0, "R7 fill write");
            if (i == 254) check(vt_full == 1'b0, "R7 one slot left", 32'(vt_full), 32'd0);
        end
        check(vt_full == 1'b1, "R7 all slots used", 32'(vt_full), 32'd1);
        do_op(RD, 0, 2, 0, 0, 0, 0, "R3 tag mismatch after fill");
        do_op(RD, 200, 1, 0, 1, 32'hA000_00C8, 0, "R2 read filled line");

        do_op(WR, 300, 2, 32'd3, 0, 0, 0, "R4 inline accepted while full");
        do_op(WR, 300, 2, 32'hDEAD_0001, 0, 0, 1, "R6 reject when full");
        do_op(RD, 300, 2, 0, 1, 32'd3, 0, "R6 line kept after reject");
        check(vt_full == 1'b1, "R6 still full", 32'(vt_full), 32'd1);

        do_op(WR, 10, 1, 32'hDEAD_0002, 0, 0, 0, "R10 sole owner reuse");
        do_op(RD, 10, 1, 0, 1, 32'hDEAD_0002, 0, "R10 new word read back");
        do_op(RD, 11, 1, 0, 1, 32'hA000_000B, 0, "R10 neighbour intact");

        do_op(WR, 301, 2, 32'hA000_0014, 0, 0, 0, "R5 shared word accepted while full");
        do_op(RD, 301, 2, 0, 1, 32'hA000_0014, 0, "R5 shared read");

        do_op(WR, 21, 1, 32'hA000_0015, 0, 0, 0, "R9 rewrite same word");
        check(vt_full == 1'b1, "R9 full after rewrite", 32'(vt_full), 32'd1);
        do_op(EV, 21, 0, 0, 0, 0, 0, "R9 evict");
        check(vt_full == 1'b0, "R9 count stayed one", 32'(vt_full), 32'd0);

        do_op(WR, 302, 0, 32'hBEEF_0000, 0, 0, 0, "R8 take last slot");
        check(vt_full == 1'b1, "R8 full again", 32'(vt_full), 32'd1);
        do_op(EV, 20, 0, 0, 0, 0, 0, "R8 evict one sharer");
        check(vt_full == 1'b1, "R8 shared slot held", 32'(vt_full), 32'd1);
        do_op(RD, 301, 2, 0, 1, 32'hA000_0014, 0, "R5 survivor reads");
        do_op(EV, 301, 0, 0, 0, 0, 0, "R8 evict last sharer");
        check(vt_full == 1'b0, "R8 slot freed", 32'(vt_full), 32'd0);
        do_op(RD, 301, 2, 0, 0, 0, 0, "R11 evicted line misses");

        do_op(WR, 400, 0, 32'hCAFE_0000, 0, 0, 0, "R8 fill again");
        check(vt_full == 1'b1, "R8 full before overwrite", 32'(vt_full), 32'd1);
        do_op(WR, 400, 0, 32'hFFFF_FF80, 0, 0, 0, "R8 overwrite with narrow");
        check(vt_full == 1'b0, "R8 overwrite released slot", 32'(vt_full), 32'd0);
        do_op(RD, 400, 0, 0, 1, 32'hFFFF_FF80, 0, "R4 lower narrow bound");

        do_op(NP, 100, 1, 32'h5555_5555, 0, 0, 0, "R1 no operation");
        do_op(RD, 100, 1, 0, 1, 32'hA000_0064, 0, "R1 no operation left line intact");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R1 all responses seen", 32'(exp_q.size()), 32'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R1 watchdog actual %0d expected %0d", 200000, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule